// File: doc/BRIEF.md
# USB FIFO Command Read Sequencer

This block pulls fixed three-byte host commands out of a synchronous parallel USB FIFO bridge. The bridge pulls an active-low data-available flag low while it holds bytes. The sequencer answers with two active-low strobes: an output-enable that turns the bridge's data bus around, and a read strobe that pops one byte on every clock it is held low. The bytes are gathered into a 24-bit command word. The word is presented to the decoder behind the block only when all three bytes arrived inside one transaction.

The controller has four states. `ST_WAIT` keeps both strobes high. It moves to `ST_BUS_ON` when the flag is seen low. `ST_BUS_ON` drives only output-enable low. It moves to `ST_FETCH` if the flag is still low, and to `ST_RELEASE` if the flag has gone high, which is an early abort. `ST_FETCH` drives both strobes low and captures one byte per clock while the flag stays low. It moves to `ST_RELEASE` after the third byte, with the completion flag set. It also moves to `ST_RELEASE` as soon as the flag rises, and then the byte index is cleared and no completion is recorded. `ST_RELEASE` drives both strobes high, pulses `cmd_valid` if the completion flag is set, clears the flag, and always returns to `ST_WAIT`. Completion and abort both leave the byte index at zero, so only the separate completion flag tells them apart.

The raw reset is asserted asynchronously and released through a two-stage synchronizer. While the synchronized reset is active the controller sits in `ST_WAIT` with both strobes high.

Top module: `usbcmd_reader`

## Requirements
- R1: While `rst_n` is low, and until the synchronized reset releases, `oe_n` and `rd_n` are 1 and `cmd_valid` is 0. With `avail_n` held high after reset, the strobes stay high.
- R2: When `avail_n` is seen low in the idle state, `oe_n` falls at the next clock edge while `rd_n` stays high. `rd_n` falls exactly one clock after `oe_n`.
- R3: While `rd_n` and `avail_n` are both low, one byte of `bus_data` is taken at each rising edge. The first byte goes to `cmd_word[23:16]` (opcode), the second to `[15:8]` and the third to `[7:0]`.
- R4: The clock edge that takes the third byte raises both strobes. In the following cycle `cmd_valid` is 1 for exactly one cycle, with the three bytes on `cmd_word`.
- R5: If `avail_n` rises while `rd_n` is low, the read stops at the next edge, both strobes go high and no `cmd_valid` is produced. The bytes of that partial command never appear on `cmd_word` with `cmd_valid`. The next command is built from the next three bytes on the bus.
- R6: If `avail_n` rises in the cycle after `oe_n` fell, before `rd_n` has fallen, the transaction ends with `rd_n` never going low and with no `cmd_valid`.
- R7: After each transaction both strobes stay high for two cycles before `oe_n` can fall again. With data continuously available, successive `cmd_valid` pulses are 6 cycles apart.
- R8: `rd_n` is never low while `oe_n` is high.
- R9: Asserting `rst_n` in mid-command forces both strobes high at once and discards the partial command. After `rst_n` rises, `oe_n` can fall no earlier than the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge-synchronous clock |
| rst_n | input | 1 | Raw active-low reset, asserted asynchronously |
| avail_n | input | 1 | Active-low data-available flag from the bridge |
| bus_data | input | 8 | Byte presented by the bridge |
| oe_n | output | 1 | Active-low output-enable to the bridge |
| rd_n | output | 1 | Active-low read strobe to the bridge |
| cmd_valid | output | 1 | One-cycle pulse marking a complete command |
| cmd_word | output | 24 | Assembled command, first byte in the top bits |

## Verification
A lost or stale completion flag shows one cycle after the controller leaves the fetch state. It appears either as a missing `cmd_valid` after three reads, or as a spurious pulse after an abort. The byte counts on the bus and the command words reveal it at once. A byte index that is not cleared on abort does not show at the abort itself. It shows at the next command, whose word comes out with its bytes in the wrong lanes. This is why every abort case is followed by a fresh complete command. Strobe ordering faults show in the very cycle the state is entered.

// File: rtl/usbcmd_pkg.sv
package usbcmd_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_BUS_ON  = 2'd1,
        ST_FETCH   = 2'd2,
        ST_RELEASE = 2'd3
    } rdseq_state_t;

endpackage

// File: rtl/usbcmd_rst_sync.sv
module usbcmd_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic eff_rst_n
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign eff_rst_n = chain[STAGES-1];

endmodule

// File: rtl/usbcmd_ctrl.sv
module usbcmd_ctrl
    import usbcmd_pkg::*;
#(
    parameter int CMD_BYTES = 3,
    localparam int CNT_W    = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1
) (
    input  logic             clk,
    input  logic             eff_rst_n,
    input  logic             avail_n,
    output logic             oe_n,
    output logic             rd_n,
    output logic             cap_en,
    output logic [CNT_W-1:0] cap_idx,
    output logic             emit
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CMD_BYTES - 1);

    rdseq_state_t state, nxt;
    logic [CNT_W-1:0] idx;
    logic             complete;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT:    if (!avail_n) nxt = ST_BUS_ON;
            ST_BUS_ON:  nxt = avail_n ? ST_RELEASE : ST_FETCH;
            ST_FETCH:   if (avail_n || idx == LAST_IDX) nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_WAIT;
        endcase
    end

    // state register, byte index and completion flag
    always_ff @(posedge clk or negedge eff_rst_n) begin
        if (!eff_rst_n) begin
            state    <= ST_WAIT;
            idx      <= '0;
            complete <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_FETCH: begin
                    if (avail_n) begin
                        idx <= '0;
                    end else if (idx == LAST_IDX) begin
                        idx      <= '0;
                        complete <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_RELEASE: complete <= 1'b0;
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        oe_n   = 1'b1;
        rd_n   = 1'b1;
        cap_en = 1'b0;
        emit   = 1'b0;
        unique case (state)
            ST_WAIT: ;
            ST_BUS_ON: oe_n = 1'b0;
            ST_FETCH: begin
                oe_n   = 1'b0;
                rd_n   = 1'b0;
                cap_en = !avail_n;
            end
            ST_RELEASE: emit = complete;
        endcase
    end

    assign cap_idx = idx;

endmodule

// File: rtl/usbcmd_pack.sv
module usbcmd_pack #(
    parameter int CMD_BYTES = 3,
    parameter int BYTE_W    = 8,
    localparam int CNT_W    = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1,
    localparam int WORD_W   = CMD_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              eff_rst_n,
    input  logic              cap_en,
    input  logic [CNT_W-1:0]  cap_idx,
    input  logic [BYTE_W-1:0] bus_data,
    output logic [WORD_W-1:0] word
);

    for (genvar b = 0; b < CMD_BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk or negedge eff_rst_n) begin
            if (!eff_rst_n) begin
                lane_q <= '0;
            end else if (cap_en && cap_idx == CNT_W'(b)) begin
                lane_q <= bus_data;
            end
        end

        // first byte received lands in the most significant lane
        assign word[(CMD_BYTES-1-b)*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/usbcmd_reader.sv
module usbcmd_reader #(
    parameter int CMD_BYTES  = 3,
    parameter int BYTE_W     = 8,
    parameter int SYNC_DEPTH = 2,
    localparam int CNT_W     = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1,
    localparam int WORD_W    = CMD_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              avail_n,
    input  logic [BYTE_W-1:0] bus_data,
    output logic              oe_n,
    output logic              rd_n,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_word
);

    logic             eff_rst_n;
    logic             cap_en;
    logic [CNT_W-1:0] cap_idx;

    usbcmd_rst_sync #(
        .STAGES (SYNC_DEPTH)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .eff_rst_n (eff_rst_n)
    );

    usbcmd_ctrl #(
        .CMD_BYTES (CMD_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .eff_rst_n (eff_rst_n),
        .avail_n   (avail_n),
        .oe_n      (oe_n),
        .rd_n      (rd_n),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .emit      (cmd_valid)
    );

    usbcmd_pack #(
        .CMD_BYTES (CMD_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_pack (
        .clk       (clk),
        .eff_rst_n (eff_rst_n),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .bus_data  (bus_data),
        .word      (cmd_word)
    );

endmodule

// File: rtl/usbcmd_reader_chk.sv
module usbcmd_reader_chk (
    input logic clk,
    input logic eff_rst_n,
    input logic avail_n,
    input logic oe_n,
    input logic rd_n,
    input logic cmd_valid
);

    // R8
    rd_needs_oe_chk: assert property (@(posedge clk) disable iff (!eff_rst_n)
        !rd_n |-> !oe_n);

    // R2
    oe_leads_rd_chk: assert property (@(posedge clk) disable iff (!eff_rst_n)
        $fell(oe_n) |-> rd_n);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!eff_rst_n)
        cmd_valid |=> !cmd_valid);

    // R4
    valid_idle_bus_chk: assert property (@(posedge clk) disable iff (!eff_rst_n)
        cmd_valid |-> (rd_n && oe_n));

    // R3
    valid_after_read_chk: assert property (@(posedge clk) disable iff (!eff_rst_n)
        cmd_valid |-> $past(!rd_n && !avail_n));

    // R5
    fetch_abort_chk: assert property (@(posedge clk) disable iff (!eff_rst_n)
        (!rd_n && avail_n) |=> (rd_n && oe_n && !cmd_valid));

    // R6
    early_abort_chk: assert property (@(posedge clk) disable iff (!eff_rst_n)
        (!oe_n && rd_n && avail_n) |=> (rd_n && oe_n && !cmd_valid));

    // R7
    release_gap_chk: assert property (@(posedge clk) disable iff (!eff_rst_n)
        cmd_valid |=> oe_n);

endmodule

bind usbcmd_reader usbcmd_reader_chk u_chk (
    .clk       (clk),
    .eff_rst_n (eff_rst_n),
    .avail_n   (avail_n),
    .oe_n      (oe_n),
    .rd_n      (rd_n),
    .cmd_valid (cmd_valid)
);

// File: tb/sim_usbcmd_reader.sv
module sim_usbcmd_reader;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        avail_n = 1'b1;
    logic [7:0]  bus_data = 8'h00;
    logic        oe_n, rd_n, cmd_valid;
    logic [23:0] cmd_word;

    int checks = 0;
    int errors = 0;

    // bridge model state
    int idx = 0;
    int limit = 0;
    int seed = 0;
    bit force_hi = 1'b0;
    bit pend = 1'b0;
    int cyc = 0;

    // monitor state
    int          ncmd = 0;
    logic [23:0] got_w [16];
    int          got_c [16];
    bit          prev_oe = 1'b1;
    bit          prev_rd = 1'b1;
    int          oe_fall_cyc = -1;
    int          rd_fall_cyc = -1;
    int          order_bad = 0;
    bit          rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbcmd_reader u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail_n   (avail_n),
        .bus_data  (bus_data),
        .oe_n      (oe_n),
        .rd_n      (rd_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word)
    );

    function automatic logic [7:0] srcb(int i);
        return 8'(i * 37 + seed * 101 + 11);
    endfunction

    function automatic logic [23:0] exp_word(int b);
        return {srcb(b), srcb(b + 1), srcb(b + 2)};
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        ncmd = 0;
        oe_fall_cyc = -1;
        rd_fall_cyc = -1;
        order_bad = 0;
        rd_seen = 1'b0;
    endtask

    // one clock: sample at the falling edge, then update bridge outputs
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cmd_valid && ncmd < 16) begin
            got_w[ncmd] = cmd_word;
            got_c[ncmd] = cyc;
            ncmd++;
        end
        if (prev_oe && !oe_n) begin
            if (!rd_n) order_bad++;
            if (oe_fall_cyc < 0) oe_fall_cyc = cyc;
        end
        if (prev_rd && !rd_n && rd_fall_cyc < 0) rd_fall_cyc = cyc;
        if (!rd_n) rd_seen = 1'b1;
        prev_oe = oe_n;
        prev_rd = rd_n;
        if (pend) idx++;
        avail_n  = force_hi || (idx >= limit);
        bus_data = srcb(idx);
        pend     = !rd_n && !avail_n;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idx = 0; limit = 0; force_hi = 1'b0; pend = 1'b0;
        avail_n = 1'b1;
        run(2);
        // R1 reset state
        check(oe_n && rd_n && !cmd_valid, "R1 strobes in reset", {oe_n, rd_n, cmd_valid}, 3'b110);
        rst_n = 1'b1;
        run(4);
        check(oe_n && rd_n && !cmd_valid, "R1 idle after reset", {oe_n, rd_n, cmd_valid}, 3'b110);
        clear_mon();
    endtask

    initial begin
        // sweep over bytes supplied and two data patterns
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 8; k++) begin
                seed = s;
                do_reset();
                limit = k;
                run(60);
                // R3 R5: every available byte is consumed
                check(idx == k, "R3 bytes consumed", idx, k);
                // R4 R5: one command per complete group of three
                check(ncmd == k / 3, "R4 command count", ncmd, k / 3);
                for (int j = 0; j < k / 3 && j < ncmd; j++) begin
                    check(got_w[j] == exp_word(3 * j), "R3 command word", got_w[j], exp_word(3 * j));
                end
                if (k >= 6 && ncmd >= 2) begin
                    check(got_c[1] - got_c[0] == 6, "R7 command spacing", got_c[1] - got_c[0], 6);
                end
                if (k >= 1) begin
                    check(rd_fall_cyc - oe_fall_cyc == 1, "R2 oe leads rd by one", rd_fall_cyc - oe_fall_cyc, 1);
                    check(order_bad == 0, "R2 rd high when oe falls", order_bad, 0);
                end else begin
                    check(oe_fall_cyc < 0, "R1 no bus activity", oe_fall_cyc, -1);
                end
                check(oe_n && rd_n, "R4 strobes released", {oe_n, rd_n}, 2'b11);
                // R5: after an abort the next command starts afresh
                if (k % 3 != 0) begin
                    clear_mon();
                    limit = k + 3;
                    run(40);
                    check(ncmd == 1, "R5 command after abort", ncmd, 1);
                    if (ncmd >= 1)
                        check(got_w[0] == exp_word(k), "R5 partial discarded", got_w[0], exp_word(k));
                end
            end
        end

        // R6: flag lost while only output-enable is low
        seed = 3;
        do_reset();
        limit = 10;
        tick();
        force_hi = 1'b1;
        run(12);
        check(oe_fall_cyc >= 0, "R6 oe asserted", oe_fall_cyc, 1);
        check(!rd_seen, "R6 rd never low", rd_seen, 0);
        check(ncmd == 0 && idx == 0, "R6 no command", ncmd, 0);
        clear_mon();
        force_hi = 1'b0;
        run(30);
        check(ncmd >= 1 && got_w[0] == exp_word(0), "R6 recovery word", got_w[0], exp_word(0));

        // R9: reset in mid-command
        seed = 4;
        do_reset();
        limit = 20;
        run(4);
        rst_n = 1'b0;
        #1;
        check(oe_n && rd_n, "R9 strobes on reset", {oe_n, rd_n}, 2'b11);
        pend = 1'b0;
        run(2);
        rst_n = 1'b1;
        limit = idx + 3;
        clear_mon();
        tick();
        check(oe_n, "R9 held after edge 1", oe_n, 1);
        tick();
        check(oe_n, "R9 held after edge 2", oe_n, 1);
        tick();
        check(!oe_n, "R9 oe after edge 3", oe_n, 0);
        begin
            int base;
            base = limit - 3;
            run(30);
            check(ncmd == 1, "R9 one command after reset", ncmd, 1);
            if (ncmd >= 1)
                check(got_w[0] == exp_word(base), "R9 fresh word", got_w[0], exp_word(base));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule